// File: doc/BRIEF.md
# Paged Codec Control Register Bank

This block holds the 16-bit control registers of an audio codec behind a plain read/write port. Registers sit at even 7-bit addresses. Writes take effect on the rising clock edge. Reads are combinational from the address.

A page field selects whether the revision and analog-special registers can be reached at all. Two protected registers accept a write only after a fixed 16-bit key has been written to the address just below them, and each key admits one write.

The bank also keeps two sticky interrupt flags, one for jack sense and one for GPIO. Both are cleared through write-one-to-clear bits, and a mode bit decides how far the common clear reaches. The bank drives the direction and data of an external enable pin and the ADC high-pass bypass control.

Top module: `codec_ctl_bank`

## Requirements
- R1: After reset, reads return 0000h at 24h, 72h and 78h, 1000h at 6Eh, and 0800h at 74h.
- R2: At 6Ch, bits 15:8 read the minor revision parameter (default 00h) and bits 7:0 read the major revision parameter. Writes to 6Ch have no effect.
- R3: Bits 3:0 of 24h are the page. While the page is not 0, reads of 6Ch and 6Eh return 0000h and writes to 6Eh are ignored.
- R4: Unimplemented bits read 0. The writable masks are 1077h at 6Eh, 8807h at 74h and 0001h at 78h. At 24h, bits 14:4 read 0.
- R5: Writing 16'hABBA to 70h unlocks exactly one write to 72h. Writing 16'hABBA to 76h unlocks exactly one write to 78h.
- R6: A write to 72h or 78h while it is locked is ignored. Any other value written to its key register re-locks it.
- R7: A sense_evt or gpio_evt pulse sets a sticky flag. Bit 15 of 24h reads the OR of both flags, bit 15 of 54h reads the GPIO flag, and `irq` is the OR of both flags.
- R8: Writing 1 to bit 15 of 24h clears the sense flag. It also clears the GPIO flag only when bit 2 of 74h is 0.
- R9: Writing 1 to bit 15 of 54h clears the GPIO flag.
- R10: An event in the same cycle as a clear of its flag leaves the flag set.
- R11: `eapd_oe` follows bit 11 of 74h and `eapd_out` follows bit 15 of 74h. While bit 11 is 0, bit 15 of 74h reads the `eapd_in` pin.
- R12: `hpf_bypass` follows bit 0 of 78h.
- R13: Unmapped and odd addresses read 0000h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| sense_evt | input | 1 | Jack-sense interrupt event pulse |
| gpio_evt | input | 1 | GPIO interrupt event pulse |
| irq | output | 1 | Any interrupt pending |
| eapd_in | input | 1 | External enable pin input value |
| eapd_out | output | 1 | External enable pin drive value |
| eapd_oe | output | 1 | External enable pin output enable |
| hpf_bypass | output | 1 | ADC high-pass filter bypass |

## Verification
Two things can land on the same edge: a new interrupt event and a write-one-to-clear of that same flag, made either through 24h or through 54h. The bench raises the event pulse in the same cycle as the clear write. It expects the flag to survive, and it also checks the case where the mode bit keeps a pending GPIO flag out of the common clear. Random runs overlap events with clear writes often, and after every operation the flags are compared with a bench model at both status bits and at `irq`.

// File: rtl/codec_ctl_bank.sv
module codec_ctl_bank #(
  parameter logic [7:0]  MAJOR_REV  = 8'h02,
  parameter logic [7:0]  MINOR_REV  = 8'h00,
  parameter logic [15:0] UNLOCK_KEY = 16'hABBA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        sense_evt,
  input  logic        gpio_evt,
  output logic        irq,
  input  logic        eapd_in,
  output logic        eapd_out,
  output logic        eapd_oe,
  output logic        hpf_bypass
);
  localparam logic [6:0] A_PAGE = 7'h24, A_GPIO = 7'h54, A_REV = 7'h6C, A_SPC = 7'h6E;
  localparam logic [6:0] A_KEYA = 7'h70, A_CUR = 7'h72, A_EAPD = 7'h74;
  localparam logic [6:0] A_KEYB = 7'h76, A_HPF = 7'h78;
  localparam logic [15:0] M_SPC = 16'h1077, M_EAPD = 16'h8807, M_HPF = 16'h0001;

  logic [3:0]  page;
  logic [15:0] r_spc, r_cur, r_eapd, r_hpf;
  logic        unlock_a, unlock_b, sense_pend, gpio_pend;

  wire pg0     = (page == 4'h0);
  wire w_page  = bus_wr && bus_addr == A_PAGE;
  wire w_gpio  = bus_wr && bus_addr == A_GPIO;
  wire clr_s   = w_page && bus_wdata[15];
  wire clr_g   = (clr_s && !r_eapd[2]) || (w_gpio && bus_wdata[15]);
  wire key_ok  = (bus_wdata == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page       <= '0;
      r_spc      <= 16'h1000;
      r_cur      <= '0;
      r_eapd     <= 16'h0800;
      r_hpf      <= '0;
      unlock_a   <= 1'b0;
      unlock_b   <= 1'b0;
      sense_pend <= 1'b0;
      gpio_pend  <= 1'b0;
    end else begin
      sense_pend <= sense_evt | (sense_pend & ~clr_s);
      gpio_pend  <= gpio_evt  | (gpio_pend  & ~clr_g);
      if (bus_wr) begin
        case (bus_addr)
          A_PAGE: page <= bus_wdata[3:0];
          A_SPC:  if (pg0) r_spc <= bus_wdata & M_SPC;
          A_KEYA: unlock_a <= key_ok;
          A_CUR:  if (unlock_a) begin r_cur <= bus_wdata; unlock_a <= 1'b0; end
          A_EAPD: r_eapd <= bus_wdata & M_EAPD;
          A_KEYB: unlock_b <= key_ok;
          A_HPF:  if (unlock_b) begin r_hpf <= bus_wdata & M_HPF; unlock_b <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  assign irq        = sense_pend | gpio_pend;
  assign eapd_oe    = r_eapd[11];
  assign eapd_out   = r_eapd[15];
  assign hpf_bypass = r_hpf[0];

  always_comb begin
    case (bus_addr)
      A_PAGE:  bus_rdata = {irq, 11'b0, page};
      A_GPIO:  bus_rdata = {gpio_pend, 15'b0};
      A_REV:   bus_rdata = pg0 ? {MINOR_REV, MAJOR_REV} : 16'h0000;
      A_SPC:   bus_rdata = pg0 ? r_spc : 16'h0000;
      A_CUR:   bus_rdata = r_cur;
      A_EAPD:  bus_rdata = {(eapd_oe ? r_eapd[15] : eapd_in), r_eapd[14:0]};
      A_HPF:   bus_rdata = r_hpf;
      default: bus_rdata = 16'h0000;
    endcase
  end
endmodule

module codec_ctl_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [6:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [3:0]  page,
  input logic        unlock_a,
  input logic [15:0] r_spc,
  input logic [15:0] r_cur,
  input logic        mode_bit,
  input logic        sense_evt,
  input logic        gpio_evt,
  input logic        sense_pend,
  input logic        gpio_pend
);
  assert_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h70 && bus_wdata == 16'hABBA |=> unlock_a);
  assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h72 |=> !unlock_a);
  assert_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h70 && bus_wdata != 16'hABBA |=> !unlock_a);
  assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h72 && !unlock_a |=> $stable(r_cur));
  assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h6E && page != 4'h0 |=> $stable(r_spc));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h24 && bus_wdata[15] && !sense_evt |=> !sense_pend);
  assert_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h24 && mode_bit && gpio_pend |=> gpio_pend);
  assert_gclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h54 && bus_wdata[15] && !gpio_evt |=> !gpio_pend);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sense_evt |=> sense_pend);
endmodule

bind codec_ctl_bank codec_ctl_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .page(page), .unlock_a(unlock_a), .r_spc(r_spc), .r_cur(r_cur), .mode_bit(r_eapd[2]),
  .sense_evt(sense_evt), .gpio_evt(gpio_evt), .sense_pend(sense_pend), .gpio_pend(gpio_pend)
);

// File: tb/codec_ctl_bank_tb.sv
`timescale 1ns/1ps
module codec_ctl_bank_tb;
  logic clk = 0, rst_n = 0, bus_wr = 0, sense_evt = 0, gpio_evt = 0, eapd_in = 0;
  logic [6:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq, eapd_out, eapd_oe, hpf_bypass;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  codec_ctl_bank u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sense_evt(sense_evt), .gpio_evt(gpio_evt),
    .irq(irq), .eapd_in(eapd_in), .eapd_out(eapd_out), .eapd_oe(eapd_oe), .hpf_bypass(hpf_bypass));

  logic [3:0] mpage = 0;
  logic [15:0] m6e = 16'h1000, m72 = 0, m74 = 16'h0800, m78 = 0;
  logic ua = 0, ub = 0, ms = 0, mg = 0;

  function automatic logic [15:0] exp_rd(input logic [6:0] a);
    case (a)
      7'h24: return {ms | mg, 11'b0, mpage};
      7'h54: return {mg, 15'b0};
      7'h6C: return (mpage == 0) ? 16'h0002 : 16'h0000;
      7'h6E: return (mpage == 0) ? m6e : 16'h0000;
      7'h72: return m72;
      7'h74: return {(m74[11] ? m74[15] : eapd_in), m74[14:0]};
      7'h78: return m78;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [6:0] a, input string req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp_rd(a));
  endtask

  task automatic out_chk();
    #1;
    chk("R7 irq", {15'b0, irq}, {15'b0, ms | mg});
    chk("R11 eapd", {14'b0, eapd_oe, eapd_out}, {14'b0, m74[11], m74[15]});
    chk("R12 hpf", {15'b0, hpf_bypass}, {15'b0, m78[0]});
  endtask

  task automatic op(input logic w, input logic [6:0] a, input logic [15:0] d,
                    input logic se, input logic ge);
    logic cs, cg;
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; sense_evt = se; gpio_evt = ge;
    cs = w && a == 7'h24 && d[15];
    cg = (cs && !m74[2]) || (w && a == 7'h54 && d[15]);
    @(negedge clk);
    bus_wr = 0; sense_evt = 0; gpio_evt = 0;
    ms = se | (ms & ~cs);
    mg = ge | (mg & ~cg);
    if (w) begin
      case (a)
        7'h24: mpage = d[3:0];
        7'h6E: if (mpage == 0) m6e = d & 16'h1077;
        7'h70: ua = (d == 16'hABBA);
        7'h72: if (ua) begin m72 = d; ua = 0; end
        7'h74: m74 = d & 16'h8807;
        7'h76: ub = (d == 16'hABBA);
        7'h78: if (ub) begin m78 = d & 16'h0001; ub = 0; end
        default: ;
      endcase
    end
    out_chk();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] alist [11] = '{7'h24, 7'h54, 7'h6C, 7'h6E, 7'h70, 7'h72, 7'h74, 7'h76, 7'h78, 7'h25, 7'h40};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R2 revision
    rd_chk(7'h24, "R1 page"); rd_chk(7'h6E, "R1 spc"); rd_chk(7'h72, "R1 cur");
    rd_chk(7'h74, "R1 eapd"); rd_chk(7'h78, "R1 hpf"); rd_chk(7'h6C, "R2 rev");
    op(1, 7'h6C, 16'hFFFF, 0, 0); rd_chk(7'h6C, "R2 rev write ignored");
    // R4 reserved bits
    op(1, 7'h6E, 16'hFFFF, 0, 0); rd_chk(7'h6E, "R4 spc mask");
    op(1, 7'h74, 16'hFFFF, 0, 0); rd_chk(7'h74, "R4 eapd mask");
    op(1, 7'h24, 16'h7FF0, 0, 0); rd_chk(7'h24, "R4 page mask");
    // R3 page gating
    op(1, 7'h24, 16'h0003, 0, 0); rd_chk(7'h6E, "R3 gated read"); rd_chk(7'h6C, "R3 gated rev");
    op(1, 7'h6E, 16'h0000, 0, 0);
    op(1, 7'h24, 16'h0000, 0, 0); rd_chk(7'h6E, "R3 gated write ignored");
    // R5 R6 keys
    op(1, 7'h72, 16'h1234, 0, 0); rd_chk(7'h72, "R6 locked write");
    op(1, 7'h70, 16'hABBA, 0, 0); op(1, 7'h72, 16'h1234, 0, 0); rd_chk(7'h72, "R5 unlocked write");
    op(1, 7'h72, 16'h5678, 0, 0); rd_chk(7'h72, "R5 one write only");
    op(1, 7'h70, 16'hABBA, 0, 0); op(1, 7'h70, 16'h0001, 0, 0);
    op(1, 7'h72, 16'h9999, 0, 0); rd_chk(7'h72, "R6 relock");
    op(1, 7'h76, 16'hABBA, 0, 0); op(1, 7'h78, 16'hFFFF, 0, 0); rd_chk(7'h78, "R5 hpf unlock");
    op(1, 7'h78, 16'h0000, 0, 0); rd_chk(7'h78, "R6 hpf locked");
    // R7-R10 interrupts
    op(0, 7'h00, 16'h0, 1, 0); rd_chk(7'h24, "R7 sense set");
    op(0, 7'h00, 16'h0, 0, 1); rd_chk(7'h54, "R7 gpio set");
    op(1, 7'h74, 16'h0804, 0, 0);
    op(1, 7'h24, 16'h8000, 0, 0); rd_chk(7'h54, "R8 mode keeps gpio"); rd_chk(7'h24, "R8 status");
    op(1, 7'h54, 16'h8000, 0, 0); rd_chk(7'h54, "R9 gpio clear");
    op(1, 7'h74, 16'h0800, 0, 1);
    op(1, 7'h24, 16'h8000, 1, 0); rd_chk(7'h24, "R10 set wins");
    op(1, 7'h24, 16'h8000, 0, 0); rd_chk(7'h24, "R8 clear both");
    op(0, 7'h00, 16'h0, 0, 1); op(1, 7'h54, 16'h8000, 0, 1); rd_chk(7'h54, "R10 gpio set wins");
    // R11 pin input
    op(1, 7'h74, 16'h0000, 0, 0); eapd_in = 1; rd_chk(7'h74, "R11 pin in high");
    eapd_in = 0; rd_chk(7'h74, "R11 pin in low");
    // R13 unmapped
    op(1, 7'h25, 16'h000F, 0, 0); rd_chk(7'h24, "R13 odd write"); rd_chk(7'h25, "R13 odd read");
    rd_chk(7'h40, "R13 unmapped read");
    // random
    for (int i = 0; i < 600; i++) begin
      logic [6:0] a;
      logic [15:0] d;
      a = alist[$urandom % 11];
      d = ($urandom % 4 == 0) ? 16'hABBA : 16'($urandom);
      if (a == 7'h24 && $urandom % 2 == 0) d[3:0] = 4'h0;
      eapd_in = 1'($urandom);
      op(1'($urandom % 4 != 0), a, d, ($urandom % 5 == 0), ($urandom % 5 == 0));
      rd_chk(alist[$urandom % 11], "R3 R4 R5 R6 R7 R8 R9 R10 R11 R13 random read");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule